// File: doc/BRIEF.md
# RTC Alarm Interrupt Controller

This block sits beside a real-time clock and turns two timekeeping events into activity on two interrupt pins. One event is the time-of-day alarm match and the other is the watchdog countdown expiry. Both arrive as single-cycle strobes from logic outside the block. An 8-bit command register sets how the pins behave. It selects which event drives which pin, whether the secondary pin is active-high or active-low, whether the pins hold a level or give a timed pulse, and whether each event is masked. The register also holds two sticky status flags, one for each event.

Software never writes the flags directly. Each flag clears as a side effect of a bus access, read or write, to the registers that belong to its event. For the alarm flag these are the alarm setting registers. For the watchdog flag they are the countdown registers. Each pin is modelled as an open-drain style output. It has a data value and an output enable, and a deasserted pin has its enable low, which means high impedance.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the command register reads 0x0C. Both mask bits (bit 3 and bit 2) are 1, every other bit is 0, and both pin enables are 0.
- R2: A bus write to the command address (0xB) stores bits 7..2 of the write data. Bits 1 and 0 of the write data are ignored and the flags keep their values. A read of 0xB returns the register on `bus_rdata`.
- R3: A time-of-day strobe sets flag bit 0 and a watchdog strobe sets flag bit 1 on the next clock edge. Each flag sets whatever the mask bits hold.
- R4: Any access (read or write) to address 3, 5 or 7 clears bit 0. An access to any other address leaves bit 0 unchanged. If a time-of-day strobe arrives in the same cycle as a clearing access, the flag stays set.
- R5: Any access to a countdown address (0xC or 0xD) clears bit 1. Accesses to other addresses leave bit 1 unchanged.
- R6: With bit 6 at 1, the time-of-day event drives INTP and the watchdog event drives INTB. With bit 6 at 0 the routing is swapped.
- R7: Bit 3 at 1 stops the watchdog event from asserting any pin. Bit 2 at 1 stops the time-of-day event from asserting any pin.
- R8: In level mode (bit 4 at 0), a pin is asserted while its routed flag is set and unmasked. The pin deasserts in the cycle after the clearing access.
- R9: In pulse mode (bit 4 at 1), an unmasked routed strobe asserts the pin for exactly PULSE_TICKS clock cycles, starting in the cycle after the strobe. A new strobe during a pulse restarts the full count. Once the pulse ends, the pin stays deasserted even while the flag remains set.
- R10: An asserted INTP always drives 0, in both modes. An asserted INTB drives the value of bit 5, so 1 means sourcing and 0 means sinking. A deasserted pin has its enable at 0 and its data at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | ADDR_W | Register address of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Command register when bus_addr is 0xB, otherwise 0 |
| tod_evt | input | 1 | Time-of-day alarm strobe |
| wd_evt | input | 1 | Watchdog countdown timeout strobe |
| intp_out | output | 1 | INTP data value |
| intp_oe | output | 1 | INTP output enable (0 = high impedance) |
| intb_out | output | 1 | INTB data value |
| intb_oe | output | 1 | INTB output enable (0 = high impedance) |

## Verification
The embedded properties check the following on every cycle:
- each strobe sets its flag, and each clearing access with no competing strobe empties it;
- command writes never disturb the flags;
- a pulse always starts after an unmasked routed strobe;
- INTP never drives high, and an idle pin never drives a 1;
- level-mode pins follow their routed, unmasked flag, and double masking silences both pins.

Only the bench scenarios can show the rest:
- the exact pulse length, and the restart of a pulse after a second strobe;
- the full table of routing, polarity and mask combinations on both pins;
- which addresses clear which flag, and that an address outside the clearing set clears nothing.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  typedef struct packed {
    logic hold;      // bit 7: stored, no effect here
    logic swap;      // bit 6: 1 = alarm->INTP, watchdog->INTB
    logic intb_hi;   // bit 5: INTB polarity when asserted
    logic pulse;     // bit 4: 1 = timed pulse, 0 = level
    logic wd_mask;   // bit 3
    logic tod_mask;  // bit 2
    logic wd_flag;   // bit 1
    logic tod_flag;  // bit 0
  } cmd_t;

  localparam logic [7:0] CMD_RESET = 8'h0C;

  // Alarm setting registers whose access clears the alarm flag.
  function automatic logic tod_alarm_hit(input int unsigned a);
    return (a == 3) || (a == 5) || (a == 7);
  endfunction

  function automatic logic countdown_hit(input int unsigned a,
                                         input int unsigned lo,
                                         input int unsigned hi);
    return (a == lo) || (a == hi);
  endfunction

  // Index 0 = INTP, index 1 = INTB.
  function automatic logic [1:0] route(input logic swap,
                                       input logic tod,
                                       input logic wd);
    return swap ? {wd, tod} : {tod, wd};
  endfunction

  // Value a pin drives when asserted.
  function automatic logic drive_value(input logic sink_only,
                                       input logic high);
    return sink_only ? 1'b0 : high;
  endfunction

endpackage

// File: rtl/rtc_irq_cmdreg.sv
module rtc_irq_cmdreg
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CMD_ADDR = 11,
  parameter int CNT_LO   = 12,
  parameter int CNT_HI   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              tod_evt,
  input  logic              wd_evt,
  output cmd_t              cmd,
  output logic              tod_clr,
  output logic              wd_clr,
  output logic              cmd_wr
);

  int unsigned addr_u;
  cmd_t        wr_view;

  always_comb begin
    addr_u  = 32'(bus_addr);
    cmd_wr  = bus_sel && bus_wr && (addr_u == 32'(CMD_ADDR));
    tod_clr = bus_sel && tod_alarm_hit(addr_u);
    wd_clr  = bus_sel && countdown_hit(addr_u, 32'(CNT_LO), 32'(CNT_HI));
    wr_view = cmd_t'(bus_wdata);
  end

  // Control bits 7..2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd.hold     <= CMD_RESET[7];
      cmd.swap     <= CMD_RESET[6];
      cmd.intb_hi  <= CMD_RESET[5];
      cmd.pulse    <= CMD_RESET[4];
      cmd.wd_mask  <= CMD_RESET[3];
      cmd.tod_mask <= CMD_RESET[2];
    end else if (cmd_wr) begin
      cmd.hold     <= wr_view.hold;
      cmd.swap     <= wr_view.swap;
      cmd.intb_hi  <= wr_view.intb_hi;
      cmd.pulse    <= wr_view.pulse;
      cmd.wd_mask  <= wr_view.wd_mask;
      cmd.tod_mask <= wr_view.tod_mask;
    end
  end

  // Sticky flags: set wins over a clearing access in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd.tod_flag <= 1'b0;
      cmd.wd_flag  <= 1'b0;
    end else begin
      if (tod_evt)      cmd.tod_flag <= 1'b1;
      else if (tod_clr) cmd.tod_flag <= 1'b0;
      if (wd_evt)       cmd.wd_flag  <= 1'b1;
      else if (wd_clr)  cmd.wd_flag  <= 1'b0;
    end
  end

  p_tod_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tod_evt |=> cmd.tod_flag);
  p_wd_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wd_evt |=> cmd.wd_flag);
  p_tod_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_clr && !tod_evt) |=> !cmd.tod_flag);
  p_wd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_clr && !wd_evt) |=> !cmd.wd_flag);
  p_flags_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !tod_evt && !wd_evt && !tod_clr && !wd_clr)
      |=> $stable({cmd.wd_flag, cmd.tod_flag}));

endmodule

// File: rtl/rtc_irq_pin.sv
module rtc_irq_pin
  import rtc_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 16,
  parameter bit SINK_ONLY   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_mode,
  input  logic active_high,
  input  logic trig,
  input  logic lvl,
  output logic pin_out,
  output logic pin_oe,
  output logic pulse_busy
);

  localparam int CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_TICKS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!pulse_mode)      cnt <= '0;
    else if (trig)             cnt <= LOAD;
    else if (cnt != '0)        cnt <= cnt - 1'b1;
  end

  always_comb begin
    pulse_busy = (cnt != '0);
    pin_oe     = pulse_mode ? pulse_busy : lvl;
    pin_out    = pin_oe && drive_value(SINK_ONLY, active_high);
  end

  p_pulse_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && trig) |=> (pin_oe || !pulse_mode));
  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);

  if (SINK_ONLY) begin : g_sink
    p_never_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_out);
  end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CMD_ADDR    = 11,
  parameter int CNT_LO      = 12,
  parameter int CNT_HI      = 13,
  parameter int PULSE_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tod_evt,
  input  logic              wd_evt,
  output logic              intp_out,
  output logic              intp_oe,
  output logic              intb_out,
  output logic              intb_oe
);

  localparam int NPINS = 2;

  cmd_t cmd;
  logic tod_clr, wd_clr, cmd_wr;
  logic tod_lvl, wd_lvl, tod_trig, wd_trig;
  logic [NPINS-1:0] pin_lvl, pin_trig, pin_hi, pin_out_w, pin_oe_w, pin_busy;

  rtc_irq_cmdreg #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .CNT_LO(CNT_LO), .CNT_HI(CNT_HI)
  ) i_cmdreg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tod_evt(tod_evt),
    .wd_evt(wd_evt), .cmd(cmd), .tod_clr(tod_clr), .wd_clr(wd_clr),
    .cmd_wr(cmd_wr)
  );

  always_comb begin
    tod_lvl   = cmd.tod_flag && !cmd.tod_mask;
    wd_lvl    = cmd.wd_flag  && !cmd.wd_mask;
    tod_trig  = tod_evt && !cmd.tod_mask;
    wd_trig   = wd_evt  && !cmd.wd_mask;
    pin_lvl   = route(cmd.swap, tod_lvl, wd_lvl);
    pin_trig  = route(cmd.swap, tod_trig, wd_trig);
    pin_hi    = {cmd.intb_hi, 1'b0};
    bus_rdata = (32'(bus_addr) == 32'(CMD_ADDR)) ? cmd : 8'h00;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    rtc_irq_pin #(
      .PULSE_TICKS(PULSE_TICKS), .SINK_ONLY(g == 0)
    ) i_pin (
      .clk(clk), .rst_n(rst_n), .pulse_mode(cmd.pulse),
      .active_high(pin_hi[g]), .trig(pin_trig[g]), .lvl(pin_lvl[g]),
      .pin_out(pin_out_w[g]), .pin_oe(pin_oe_w[g]), .pulse_busy(pin_busy[g])
    );
  end

  assign intp_out = pin_out_w[0];
  assign intp_oe  = pin_oe_w[0];
  assign intb_out = pin_out_w[1];
  assign intb_oe  = pin_oe_w[1];

  p_level_tod_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.pulse && cmd.tod_flag && !cmd.tod_mask)
      |-> (cmd.swap ? intp_oe : intb_oe));
  p_level_wd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.pulse && cmd.wd_flag && !cmd.wd_mask)
      |-> (cmd.swap ? intb_oe : intp_oe));
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.pulse && cmd.tod_mask && cmd.wd_mask) |-> (!intp_oe && !intb_oe));
  p_intb_polarity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    intb_oe |-> (intb_out == cmd.intb_hi));

endmodule

// File: tb/test_rtc_irq_ctrl.sv
module test_rtc_irq_ctrl;

  localparam int P = 16;
  localparam int NV = 11;
  // {cmd[7:0], tod, wd, 2'b0, exp intp_oe, intp_out, intb_oe, intb_out}
  localparam logic [15:0] VEC [NV] = '{
    {8'h40, 2'b10, 2'b00, 4'b1000},
    {8'h40, 2'b01, 2'b00, 4'b0010},
    {8'h60, 2'b01, 2'b00, 4'b0011},
    {8'h00, 2'b10, 2'b00, 4'b0010},
    {8'h20, 2'b10, 2'b00, 4'b0011},
    {8'h00, 2'b01, 2'b00, 4'b1000},
    {8'h44, 2'b10, 2'b00, 4'b0000},
    {8'h48, 2'b01, 2'b00, 4'b0000},
    {8'h4C, 2'b11, 2'b00, 4'b0000},
    {8'h08, 2'b10, 2'b00, 4'b0010},
    {8'h60, 2'b11, 2'b00, 4'b1011}
  };

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic tod_evt = 0, wd_evt = 0;
  logic intp_out, intp_oe, intb_out, intb_oe;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_irq_ctrl #(.PULSE_TICKS(P)) i_rtc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tod_evt(tod_evt), .wd_evt(wd_evt), .intp_out(intp_out),
    .intp_oe(intp_oe), .intb_out(intb_out), .intb_oe(intb_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pins();
    return {4'b0, intp_oe, intp_out, intb_oe, intb_out};
  endfunction

  // One bus access, optionally with strobes in the same cycle.
  task automatic access(input logic [3:0] a, input logic wr, input logic [7:0] d,
                        input logic te, input logic we);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    tod_evt = te; wd_evt = we;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tod_evt = 0; wd_evt = 0;
  endtask

  task automatic strobe(input logic te, input logic we);
    @(negedge clk);
    tod_evt = te; wd_evt = we;
    @(negedge clk);
    tod_evt = 0; wd_evt = 0;
  endtask

  task automatic read_cmd(output logic [7:0] v);
    bus_addr = 4'hB;
    #1 v = bus_rdata;
  endtask

  task automatic clear_all();
    access(4'h3, 1'b0, 8'h00, 1'b0, 1'b0);
    access(4'hC, 1'b1, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    read_cmd(v);
    check("R1 reset cmd", v, 8'h0C);
    check("R1 reset pins", pins(), 8'h00);

    // R2: writes keep bits 7..2, low bits ignored
    access(4'hB, 1'b1, 8'hFF, 1'b0, 1'b0);
    read_cmd(v); check("R2 write FF", v, 8'hFC);
    strobe(1'b1, 1'b0);
    access(4'hB, 1'b1, 8'h40, 1'b0, 1'b0);
    read_cmd(v); check("R2 flag kept on write", v, 8'h41);
    access(4'hB, 1'b1, 8'h4E, 1'b0, 1'b0);
    read_cmd(v); check("R2 low bits write ignored", v, 8'h4D);
    clear_all();

    // Table walk: routing, masks, polarity in level mode
    for (int i = 0; i < NV; i++) begin
      logic [7:0] c;
      c = VEC[i][15:8];
      access(4'hB, 1'b1, c, 1'b0, 1'b0);
      strobe(VEC[i][7], VEC[i][6]);
      check($sformatf("R6 R7 R10 vec%0d pins", i), pins(), {4'b0, VEC[i][3:0]});
      read_cmd(v);
      check($sformatf("R3 vec%0d flags", i), v, {c[7:2], VEC[i][6], VEC[i][7]});
      clear_all();
      read_cmd(v);
      check($sformatf("R4 R5 vec%0d cleared", i), v, {c[7:2], 2'b00});
      check($sformatf("R8 vec%0d released", i), pins(), 8'h00);
    end

    // R4 address selectivity and set priority
    access(4'hB, 1'b1, 8'h40, 1'b0, 1'b0);
    strobe(1'b1, 1'b0);
    access(4'h4, 1'b0, 8'h00, 1'b0, 1'b0);
    access(4'hC, 1'b0, 8'h00, 1'b0, 1'b0);
    read_cmd(v); check("R4 addr 4 and C keep alarm flag", v, 8'h41);
    check("R8 INTP held by flag", pins(), 8'h08);
    access(4'h5, 1'b0, 8'h00, 1'b0, 1'b0);
    read_cmd(v); check("R4 read 5 clears", v, 8'h40);
    check("R8 INTP released", pins(), 8'h00);
    strobe(1'b1, 1'b0);
    access(4'h7, 1'b1, 8'h00, 1'b0, 1'b0);
    read_cmd(v); check("R4 write 7 clears", v, 8'h40);
    access(4'h3, 1'b0, 8'h00, 1'b1, 1'b0);
    read_cmd(v); check("R4 strobe wins over clear", v, 8'h41);
    clear_all();

    // R5 address selectivity
    strobe(1'b0, 1'b1);
    access(4'h3, 1'b0, 8'h00, 1'b0, 1'b0);
    read_cmd(v); check("R5 addr 3 keeps watchdog flag", v, 8'h42);
    access(4'hD, 1'b0, 8'h00, 1'b0, 1'b0);
    read_cmd(v); check("R5 read D clears", v, 8'h40);

    // R9 pulse mode on INTP (sinks)
    access(4'hB, 1'b1, 8'h50, 1'b0, 1'b0);
    strobe(1'b1, 1'b0);
    check("R9 pulse first cycle", pins(), 8'h08);
    repeat (P - 1) @(negedge clk);
    #1 check("R9 pulse last cycle", pins(), 8'h08);
    @(negedge clk);
    #1 check("R9 pulse ended, flag still set", pins(), 8'h00);
    read_cmd(v); check("R9 flag stays after pulse", v, 8'h51);
    clear_all();

    // R9 restart
    strobe(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    strobe(1'b1, 1'b0);
    repeat (P - 1) @(negedge clk);
    #1 check("R9 restarted pulse still on", pins(), 8'h08);
    @(negedge clk);
    #1 check("R9 restarted pulse ended", pins(), 8'h00);
    clear_all();

    // R10 INTB sourcing pulse, R7 masked pulse
    access(4'hB, 1'b1, 8'h70, 1'b0, 1'b0);
    strobe(1'b0, 1'b1);
    check("R10 INTB pulse sources", pins(), 8'h03);
    repeat (P) @(negedge clk);
    access(4'hB, 1'b1, 8'h54, 1'b0, 1'b0);
    strobe(1'b1, 1'b0);
    check("R7 masked strobe gives no pulse", pins(), 8'h00);
    clear_all();

    done = 1;
    finish_run();
  end

endmodule